// File: doc/BRIEF.md
# Flash Page Access Guard

This block decides whether a flash access may proceed. It holds a bank of protection regions. Each region covers a range of 4 KB pages given by an inclusive start page and an inclusive limit page. Each region also carries two per-master permission bitmaps, one for write/erase and one for read. A requester presents a byte address, a master number and the access type. One clock later the block returns a grant or a deny.

Software fills the regions through a narrow write port: a region number, a field selector and a data word. Any region can be frozen with a set-only lock bit, which keeps its contents until reset. Master 0 is always granted. Every other master needs at least one matching region that lets it perform the requested kind of access. To disable a region, give it a start page above its limit page.

Top module: `flash_region_guard`

## Requirements
- R1: After reset every region holds start page 0x7FFFF, limit page 0, write bitmap 0x01 and read bitmap 0x01, all locks are clear, and rsp_valid is 0. So before any programming, masters 1..7 are denied at every address and master 0 is granted.
- R2: rsp_valid is high exactly in the cycle after a cycle with q_valid high. rsp_grant in that cycle carries the decision for the query presented one cycle earlier.
- R3: An address hits a region when its page number q_addr[31:12] is at least the start page and at most the limit page. Both bounds are inclusive.
- R4: For q_write=1 the decision uses bit q_master of the hit region's write/erase bitmap. For q_write=0 it uses bit q_master of the read bitmap. A bit value of 1 means allowed.
- R5: When regions overlap, the access is granted if any hit region allows it.
- R6: For masters other than 0, an address that hits no region is denied.
- R7: A query from master 0 is always granted, for reads and writes alike.
- R8: A region whose start page is greater than its limit page hits no address, whatever its bitmaps hold.
- R9: Driving bit i of lock_set high sets the lock of region i. Locks are never cleared except by reset. While region i is locked, configuration writes to it have no effect. A write issued in the same cycle as the lock set still lands.
- R10: Configuration writes with cfg_wr_en=1 update region cfg_region, field cfg_field. Field codes: 0 = start page, 1 = limit page, 2 = write/erase bitmap taken from cfg_data[7:0], 3 = read bitmap taken from cfg_data[7:0]. Region numbers 17 and above are ignored.
- R11: rsp_grant is 0 in every cycle where rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_region | input | 5 | Region number for the write |
| cfg_field | input | 2 | Field selector (start, limit, write map, read map) |
| cfg_data | input | 20 | Write data (page number or bitmap in low bits) |
| lock_set | input | 17 | One bit per region; 1 sets that region's lock |
| q_valid | input | 1 | Query present |
| q_addr | input | 32 | Flash byte address of the query |
| q_master | input | 3 | Requesting master number |
| q_write | input | 1 | 1 = write/erase, 0 = read |
| rsp_valid | output | 1 | Decision present (one cycle after the query) |
| rsp_grant | output | 1 | 1 = access allowed |

## Verification
The hardest condition to reach is a locked region that receives a configuration write which would change a decision. Lock state cannot be read back, so the bench first opens a region to a non-zero master and locks it. It then writes a bitmap that would revoke access and queries again: the grant must persist. A reset follows, after which the same query must be denied. Overlapping regions and the exact first and last page of each range are covered by the vector table, including the page at the very top of the address space.

// File: rtl/fpr_pkg.sv
// Shared definitions for the flash page access guard.
// Assumes page numbers are at least as wide as the master bitmaps.
package fpr_pkg;
    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_WPERM = 2'd2,
        FLD_RPERM = 2'd3
    } fpr_field_e;
endpackage

// File: rtl/fpr_region_slot.sv
// One protection region: stores start/limit pages and two permission maps,
// accepts configuration writes unless locked, and reports whether the current
// query hits the region and is permitted by it.
// Assumes PAGE_W >= NMST so bitmaps fit in the write data word.
module fpr_region_slot
    import fpr_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int NMST   = 8,
    parameter int PAGE_W = 20,
    parameter int RID_W  = 5,
    localparam int MID_W = $clog2(NMST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RID_W-1:0]  wr_region,
    input  logic [1:0]        wr_field,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic              locked,
    input  logic [PAGE_W-1:0] q_page,
    input  logic [MID_W-1:0]  q_master,
    input  logic              q_write,
    output logic              permit
);
    localparam logic [PAGE_W-1:0] START_RST = {1'b0, {(PAGE_W-1){1'b1}}};
    localparam logic [NMST-1:0]   MAP_RST   = NMST'(1);

    logic [PAGE_W-1:0] start_q, limit_q;
    logic [NMST-1:0]   wmap_q, rmap_q;
    logic              sel;
    logic              hit;

    assign sel = wr_en && !locked && (wr_region == RID_W'(IDX));

    // Region field storage with lock-gated updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= START_RST;
            limit_q <= '0;
            wmap_q  <= MAP_RST;
            rmap_q  <= MAP_RST;
        end else if (sel) begin
            case (fpr_field_e'(wr_field))
                FLD_START: start_q <= wr_data;
                FLD_LIMIT: limit_q <= wr_data;
                FLD_WPERM: wmap_q  <= wr_data[NMST-1:0];
                FLD_RPERM: rmap_q  <= wr_data[NMST-1:0];
                default:   start_q <= start_q;
            endcase
        end
    end

    // Inclusive page range compare and per-type permission pick
    always_comb begin
        hit    = (q_page >= start_q) && (q_page <= limit_q);
        permit = hit && (q_write ? wmap_q[q_master] : rmap_q[q_master]);
    end
endmodule

// File: rtl/fpr_lock_ctrl.sv
// Set-only lock bits, one per region; cleared only by reset.
module fpr_lock_ctrl #(
    parameter int NREG = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_req,
    output logic [NREG-1:0] lock_q
);
    // Accumulate requested locks
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_q | set_req;
    end
endmodule

// File: rtl/flash_region_guard.sv
// Top of the flash page access guard: a bank of region slots, a lock
// register, an OR over per-region permits, a master-0 override and a
// registered decision. Queries see region state as of the query cycle.
module flash_region_guard #(
    parameter int NREG       = 17,
    parameter int NMST       = 8,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
    localparam int RID_W     = $clog2(NREG),
    localparam int MID_W     = $clog2(NMST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [RID_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_field,
    input  logic [PAGE_W-1:0] cfg_data,
    input  logic [NREG-1:0]   lock_set,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [MID_W-1:0]  q_master,
    input  logic              q_write,
    output logic              rsp_valid,
    output logic              rsp_grant
);
    logic [NREG-1:0]   lock_q;
    logic [NREG-1:0]   permit_vec;
    logic [PAGE_W-1:0] q_page;
    logic              grant_c;

    assign q_page = q_addr[ADDR_W-1:PAGE_SHIFT];

    fpr_lock_ctrl #(.NREG(NREG)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (lock_set),
        .lock_q  (lock_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        fpr_region_slot #(
            .IDX    (g),
            .NMST   (NMST),
            .PAGE_W (PAGE_W),
            .RID_W  (RID_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_wr_en),
            .wr_region (cfg_region),
            .wr_field  (cfg_field),
            .wr_data   (cfg_data),
            .locked    (lock_q[g]),
            .q_page    (q_page),
            .q_master  (q_master),
            .q_write   (q_write),
            .permit    (permit_vec[g])
        );
    end

    // Combine region permits with the privileged-master override
    always_comb grant_c = (q_master == '0) || (|permit_vec);

    // Register the decision one cycle after the query
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
        end else begin
            rsp_valid <= q_valid;
            rsp_grant <= q_valid && grant_c;
        end
    end
endmodule

// File: rtl/flash_region_guard_chk.sv
// Property checker for flash_region_guard, attached by bind.
module flash_region_guard_chk #(
    parameter int NREG  = 17,
    parameter int MID_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q_valid,
    input logic [MID_W-1:0] q_master,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [NREG-1:0]  lock_vec
);
    // R2
    rsp_follows_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !rsp_valid);
    // R11
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_grant);
    // R7
    master0_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_master == '0) |=> rsp_grant);
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_vec & $past(lock_vec)) == $past(lock_vec)));
endmodule

bind flash_region_guard flash_region_guard_chk #(.NREG(NREG), .MID_W(MID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_valid   (q_valid),
    .q_master  (q_master),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .lock_vec  (lock_q)
);

// File: tb/test_flash_region_guard.sv
module test_flash_region_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_region = '0;
    logic [1:0]  cfg_field = '0;
    logic [19:0] cfg_data = '0;
    logic [16:0] lock_set = '0;
    logic        q_valid = 1'b0;
    logic [31:0] q_addr = '0;
    logic [2:0]  q_master = '0;
    logic        q_write = 1'b0;
    logic        rsp_valid, rsp_grant;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    flash_region_guard i_flash_region_guard (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_region(cfg_region),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .lock_set(lock_set),
        .q_valid(q_valid), .q_addr(q_addr), .q_master(q_master), .q_write(q_write),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  mst;
        logic        wr;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{32'h0000_FFFF, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 below start
        '{32'h0001_0000, 3'd1, 1'b0, 1'b1, 4'd3},  // R3 first page
        '{32'h0001_FFFF, 3'd1, 1'b0, 1'b1, 4'd3},  // R3 last page
        '{32'h0002_0000, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 past limit
        '{32'h0001_0000, 3'd1, 1'b1, 1'b0, 4'd4},  // R4 read-only master
        '{32'h0001_0000, 3'd2, 1'b1, 1'b1, 4'd4},  // R4 write map
        '{32'h0001_8000, 3'd3, 1'b1, 1'b1, 4'd5},  // R5 overlap, second region
        '{32'h0001_8000, 3'd2, 1'b1, 1'b1, 4'd5},  // R5 overlap, first region
        '{32'h0001_8000, 3'd4, 1'b1, 1'b0, 4'd5},  // R5 neither allows
        '{32'h0003_0FFF, 3'd3, 1'b0, 1'b1, 4'd3},  // R3 inclusive limit
        '{32'h0003_1000, 3'd3, 1'b0, 1'b0, 4'd3},  // R3 one page beyond
        '{32'h0004_5000, 3'd1, 1'b0, 1'b0, 4'd8},  // R8 inverted region
        '{32'h0004_5000, 3'd7, 1'b1, 1'b0, 4'd8},  // R8 inverted region
        '{32'hFFFF_F000, 3'd7, 1'b1, 1'b1, 4'd3},  // R3 top page
        '{32'hFFFF_E000, 3'd7, 1'b1, 1'b0, 4'd3},  // R3 page below top
        '{32'h8000_0000, 3'd4, 1'b0, 1'b0, 4'd6},  // R6 no hit
        '{32'h8000_0000, 3'd0, 1'b1, 1'b1, 4'd7},  // R7 master 0 write
        '{32'h0000_0000, 3'd0, 1'b0, 1'b1, 4'd7},  // R7 master 0 read
        '{32'h0001_4000, 3'd1, 1'b0, 1'b1, 4'd10}, // R10 read map field
        '{32'h0001_4000, 3'd6, 1'b0, 1'b0, 4'd10}  // R10 bit 6 clear
    };

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic cfg_wr(input int rg, input int fld, input logic [19:0] d);
        cfg_wr_en  = 1'b1;
        cfg_region = 5'(rg);
        cfg_field  = 2'(fld);
        cfg_data   = d;
        @(negedge clk);
        cfg_wr_en  = 1'b0;
    endtask

    task automatic query(input logic [31:0] a, input logic [2:0] m, input logic w,
                         input logic exp, input string what);
        q_valid  = 1'b1;
        q_addr   = a;
        q_master = m;
        q_write  = w;
        @(negedge clk);
        q_valid  = 1'b0;
        check(rsp_valid, 1'b1, {what, " (R2 valid)"});
        check(rsp_grant, exp, what);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(rsp_valid, 1'b0, "R1 rsp_valid after reset");
        query(32'h0000_0000, 3'd1, 1'b0, 1'b0, "R1 master1 read at 0");
        query(32'h7FFF_F000, 3'd5, 1'b1, 1'b0, "R1 master5 write at page 7FFFF");
        query(32'h1234_5000, 3'd0, 1'b1, 1'b1, "R1 master0 granted");
        // R11 idle cycle keeps grant low
        @(negedge clk);
        check(rsp_valid, 1'b0, "R11 idle valid");
        check(rsp_grant, 1'b0, "R11 idle grant");

        // R10 programming through field codes
        cfg_wr(0, 0, 20'h00010); cfg_wr(0, 1, 20'h0001F);
        cfg_wr(0, 2, 20'h00004); cfg_wr(0, 3, 20'h00006);
        cfg_wr(5, 0, 20'h00018); cfg_wr(5, 1, 20'h00030);
        cfg_wr(5, 2, 20'h00008); cfg_wr(5, 3, 20'h00008);
        cfg_wr(3, 0, 20'h00050); cfg_wr(3, 1, 20'h00040);
        cfg_wr(3, 2, 20'h000FF); cfg_wr(3, 3, 20'h000FF);
        cfg_wr(16, 0, 20'hFFFFF); cfg_wr(16, 1, 20'hFFFFF);
        cfg_wr(16, 2, 20'h00080); cfg_wr(16, 3, 20'h00080);
        cfg_wr(20, 0, 20'h00000); // out-of-range region number, ignored (R10)

        for (int i = 0; i < NV; i++) begin
            query(VEC[i].addr, VEC[i].mst, VEC[i].wr, VEC[i].exp,
                  $sformatf("table vector %0d requirement R%0d", i, VEC[i].req));
        end

        // R9 lock: region 0 frozen, revoking write ignored
        lock_set = 17'h00001;
        @(negedge clk);
        lock_set = '0;
        cfg_wr(0, 3, 20'h00000);
        query(32'h0001_0000, 3'd1, 1'b0, 1'b1, "R9 locked read map unchanged");
        cfg_wr(0, 1, 20'h00010);
        query(32'h0001_F000, 3'd1, 1'b0, 1'b1, "R9 locked limit unchanged");
        // R9 write in same cycle as lock set still lands
        cfg_wr_en = 1'b1; cfg_region = 5'd5; cfg_field = 2'd3; cfg_data = 20'h00002;
        lock_set = 17'h00020;
        @(negedge clk);
        cfg_wr_en = 1'b0; lock_set = '0;
        query(32'h0002_8000, 3'd1, 1'b0, 1'b1, "R9 same-cycle write lands");
        cfg_wr(5, 3, 20'h00000);
        query(32'h0002_8000, 3'd1, 1'b0, 1'b1, "R9 region 5 locked after");

        // R1 and R9: reset clears locks and contents
        do_reset();
        query(32'h0001_0000, 3'd1, 1'b0, 1'b0, "R1 region 0 back to reset");
        cfg_wr(0, 0, 20'h00010); cfg_wr(0, 1, 20'h00010); cfg_wr(0, 3, 20'h00002);
        query(32'h0001_0000, 3'd1, 1'b0, 1'b1, "R9 unlocked after reset");
        query(32'h0001_0000, 3'd1, 1'b1, 1'b0, "R4 write map still reset value");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule